// File: doc/BRIEF.md
# Power Stage Protection Latch Controller

This block holds the digital protection and status logic for an amplifier output stage made of two half-bridges. It takes three fault comparator flags (overcurrent, over-temperature error, undervoltage), a temperature warning flag, an active-low mute/recovery input and the strap pins that choose the protection and output modes. It produces one enable that lets the half-bridges switch (low means both are held in high impedance) and two status lines that idle high in the style of open-drain outputs: a shutdown/fault line and a temperature warning line. A controller reads the pair of status lines to find out why the stage stopped.

Every fault flag and the mute input arrive asynchronously. Each passes through a flop chain, and all decisions are taken on the synchronized copies. After any fault the stage stays silent until the mute input is pulled low and then released with no fault present. The latch is cleared when the mute input falls, and switching restarts only when it rises again. A fault that is still present at the release sets the latch again at once.

Top module: `pstage_prot_ctrl`

## Requirements
- R1: While the system reset `rst` is high and in the first cycle after it, `bridge_en` is 0, `sd_n` is 1, `otw_n` is 1.
- R2: With a valid configuration, `amp_rst_n` high and no flags active, `bridge_en` is 1 and the status pair {`otw_n`,`sd_n`} reads 2'b11.
- R3: An overcurrent or undervoltage flag while running drives `bridge_en` to 0 and the status pair to 2'b10, and both stay so after the flag clears while `amp_rst_n` stays high.
- R4: An over-temperature error flag drives `bridge_en` to 0 and the status pair to 2'b00, held after the flag clears while `amp_rst_n` stays high.
- R5: The warning flag alone gives status pair 2'b01 and does not stop switching; `otw_n` returns to 1 when the flag clears.
- R6: While the synchronized `amp_rst_n` is low, `bridge_en` is 0 and `sd_n` is 1 whatever faults were latched.
- R7: The latch is cleared on the falling edge of `amp_rst_n`; once it rises with no flag active, `bridge_en` returns to 1 and the status pair to 2'b11.
- R8: A fault flag still active when `amp_rst_n` rises sets the latch again at once: `bridge_en` stays 0 and `sd_n` goes low.
- R9: Only `prot_mode` = 2'b01 ({M1,M2}) with `out_mode` = 0 is valid; any other code sets `cfg_err` to 1 and holds `bridge_en` at 0, and a valid code gives `cfg_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| amp_rst_n | input | 1 | Active-low mute and fault recovery input, asynchronous |
| oc_flag | input | 1 | Overcurrent comparator flag, asynchronous |
| ote_flag | input | 1 | Over-temperature error flag, asynchronous |
| uv_flag | input | 1 | Undervoltage flag, asynchronous |
| warn_flag | input | 1 | Temperature above warning threshold, asynchronous |
| prot_mode | input | 2 | Protection mode strap, bit 1 = M1, bit 0 = M2 |
| out_mode | input | 1 | Output mode strap, 0 = bridge-tied load |
| bridge_en | output | 1 | 1 = half-bridges switch, 0 = high impedance |
| sd_n | output | 1 | Shutdown status, low = fault latched |
| otw_n | output | 1 | Temperature warning status, low = warning or error |
| cfg_err | output | 1 | Reserved mode code selected |

## Verification
The hardest situation to reach is a fault that is still present at the moment the mute input is released. A naive design would let the stage switch for one cycle there. The stimulus holds the mute input low, raises the undervoltage flag and only then releases mute. It checks that the stage never comes back and that the fault appears on the status lines. It then drops the flag and checks that the latch still holds until a second low-high cycle of the mute input.

// File: rtl/pstage_pkg.sv
package pstage_pkg;
  localparam logic [1:0] PROT_LATCHING = 2'b01;
  localparam logic       OUT_BTL       = 1'b0;

  // index of each flag inside the synchronized vector
  localparam int IDX_RSTN = 0;
  localparam int IDX_OC   = 1;
  localparam int IDX_OTE  = 2;
  localparam int IDX_UV   = 3;
  localparam int IDX_WARN = 4;
  localparam int NUM_SYNC = 5;

  function automatic logic cfg_valid(input logic [1:0] pm, input logic om);
    return (pm == PROT_LATCHING) && (om == OUT_BTL);
  endfunction
endpackage

// File: rtl/pstage_sync.sv
module pstage_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pstage_fault_latch.sv
module pstage_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic rstn_s,
  input  logic ocuv_s,
  input  logic ote_s,
  output logic ocuv_lat,
  output logic ote_lat,
  output logic ocuv_nx,
  output logic ote_nx
);
  logic rstn_d;
  logic rstn_fall;

  assign rstn_fall = rstn_d & ~rstn_s;

  always_comb begin
    if (rstn_fall) begin
      ocuv_nx = 1'b0;
      ote_nx  = 1'b0;
    end else begin
      ocuv_nx = ocuv_lat | (rstn_s & ocuv_s);
      ote_nx  = ote_lat  | (rstn_s & ote_s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstn_d   <= 1'b0;
      ocuv_lat <= 1'b0;
      ote_lat  <= 1'b0;
    end else begin
      rstn_d   <= rstn_s;
      ocuv_lat <= ocuv_nx;
      ote_lat  <= ote_nx;
    end
  end
endmodule

// File: rtl/pstage_out_ctl.sv
module pstage_out_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rstn_s,
  input  logic cfg_ok,
  input  logic warn_s,
  input  logic ocuv_nx,
  input  logic ote_nx,
  output logic bridge_en,
  output logic sd_n,
  output logic otw_n,
  output logic cfg_err
);
  logic fault_nx;
  assign fault_nx = ocuv_nx | ote_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      bridge_en <= 1'b0;
      sd_n      <= 1'b1;
      otw_n     <= 1'b1;
      cfg_err   <= 1'b0;
    end else begin
      bridge_en <= rstn_s & ~fault_nx & cfg_ok;
      sd_n      <= ~rstn_s | ~fault_nx;
      otw_n     <= ~(warn_s | ote_nx);
      cfg_err   <= ~cfg_ok;
    end
  end
endmodule

// File: rtl/pstage_prot_ctrl.sv
module pstage_prot_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       amp_rst_n,
  input  logic       oc_flag,
  input  logic       ote_flag,
  input  logic       uv_flag,
  input  logic       warn_flag,
  input  logic [1:0] prot_mode,
  input  logic       out_mode,
  output logic       bridge_en,
  output logic       sd_n,
  output logic       otw_n,
  output logic       cfg_err
);
  import pstage_pkg::*;

  logic [NUM_SYNC-1:0] raw_v, syn_v;
  logic rstn_s, ocuv_s, ote_s, warn_s, cfg_ok;
  logic ocuv_lat, ote_lat, ocuv_nx, ote_nx;

  always_comb begin
    raw_v           = '0;
    raw_v[IDX_RSTN] = amp_rst_n;
    raw_v[IDX_OC]   = oc_flag;
    raw_v[IDX_OTE]  = ote_flag;
    raw_v[IDX_UV]   = uv_flag;
    raw_v[IDX_WARN] = warn_flag;
  end

  pstage_sync #(.W(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign rstn_s = syn_v[IDX_RSTN];
  assign ocuv_s = syn_v[IDX_OC] | syn_v[IDX_UV];
  assign ote_s  = syn_v[IDX_OTE];
  assign warn_s = syn_v[IDX_WARN];
  assign cfg_ok = cfg_valid(prot_mode, out_mode);

  pstage_fault_latch u_latch (
    .clk(clk), .rst(rst), .rstn_s(rstn_s), .ocuv_s(ocuv_s), .ote_s(ote_s),
    .ocuv_lat(ocuv_lat), .ote_lat(ote_lat), .ocuv_nx(ocuv_nx), .ote_nx(ote_nx)
  );

  pstage_out_ctl u_out (
    .clk(clk), .rst(rst), .rstn_s(rstn_s), .cfg_ok(cfg_ok), .warn_s(warn_s),
    .ocuv_nx(ocuv_nx), .ote_nx(ote_nx),
    .bridge_en(bridge_en), .sd_n(sd_n), .otw_n(otw_n), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/pstage_prot_checker.sv
module pstage_prot_checker (
  input logic clk,
  input logic rst,
  input logic rstn_s,
  input logic fault_now,
  input logic any_lat,
  input logic bridge_en,
  input logic sd_n,
  input logic cfg_err
);
  assert_mute_R6: assert property (@(posedge clk) disable iff (rst)
    !rstn_s |=> (!bridge_en && sd_n));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (any_lat && rstn_s) |=> !bridge_en);

  assert_run_no_fault_R2: assert property (@(posedge clk) disable iff (rst)
    bridge_en |-> sd_n);

  assert_relatch_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(rstn_s) && fault_now) |=> (!bridge_en && !sd_n));

  assert_cfg_block_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !bridge_en);
endmodule

bind pstage_prot_ctrl pstage_prot_checker u_chk (
  .clk(clk), .rst(rst), .rstn_s(rstn_s), .fault_now(ocuv_s | ote_s),
  .any_lat(ocuv_lat | ote_lat), .bridge_en(bridge_en), .sd_n(sd_n),
  .cfg_err(cfg_err)
);

// File: tb/pstage_prot_ctrl_test.sv
module pstage_prot_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic amp_rst_n = 1'b0;
  logic oc_flag = 1'b0, ote_flag = 1'b0, uv_flag = 1'b0, warn_flag = 1'b0;
  logic [1:0] prot_mode = 2'b01;
  logic out_mode = 1'b0;
  logic bridge_en, sd_n, otw_n, cfg_err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pstage_prot_ctrl uut (
    .clk(clk), .rst(rst), .amp_rst_n(amp_rst_n), .oc_flag(oc_flag),
    .ote_flag(ote_flag), .uv_flag(uv_flag), .warn_flag(warn_flag),
    .prot_mode(prot_mode), .out_mode(out_mode), .bridge_en(bridge_en),
    .sd_n(sd_n), .otw_n(otw_n), .cfg_err(cfg_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compares {bridge_en, otw_n, sd_n}
  task automatic expect3(input string req, input logic [2:0] exp);
    checks++;
    if ({bridge_en, otw_n, sd_n} !== exp) begin
      fails++;
      $display("FAIL %s: {bridge_en,otw_n,sd_n} actual %b expected %b", req,
               {bridge_en, otw_n, sd_n}, exp);
    end
  endtask

  task automatic expect_cfg(input string req, input logic exp);
    checks++;
    if (cfg_err !== exp) begin
      fails++;
      $display("FAIL %s: cfg_err actual %b expected %b", req, cfg_err, exp);
    end
  endtask

  task automatic toggle_recover(input string req);
    amp_rst_n = 1'b0; step(6);
    expect3({req, " mute R6"}, 3'b011);
    amp_rst_n = 1'b1; step(6);
    expect3({req, " resume R7"}, 3'b111);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3);
    expect3("R1 in reset", 3'b011);
    rst = 1'b0; step(1);
    expect3("R1 after reset", 3'b011);
  endtask

  task automatic t_normal();
    amp_rst_n = 1'b1; step(6);
    expect3("R2 running", 3'b111);
    expect_cfg("R2 valid config", 1'b0);
  endtask

  task automatic t_ocuv(input bit use_uv);
    if (use_uv) uv_flag = 1'b1; else oc_flag = 1'b1;
    step(3);
    uv_flag = 1'b0; oc_flag = 1'b0;
    step(6);
    expect3(use_uv ? "R3 uv latched" : "R3 oc latched", 3'b010);
    step(10);
    expect3("R3 still held", 3'b010);
    toggle_recover("R3");
  endtask

  task automatic t_ote();
    ote_flag = 1'b1; step(3);
    ote_flag = 1'b0; step(6);
    expect3("R4 ote latched", 3'b000);
    step(10);
    expect3("R4 still held", 3'b000);
    toggle_recover("R4");
  endtask

  task automatic t_warn();
    warn_flag = 1'b1; step(6);
    expect3("R5 warning only", 3'b101);
    warn_flag = 1'b0; step(6);
    expect3("R5 warning cleared", 3'b111);
  endtask

  task automatic t_fault_at_release();
    amp_rst_n = 1'b0; step(6);
    uv_flag = 1'b1; step(6);
    expect3("R6 mute with fault present", 3'b011);
    amp_rst_n = 1'b1; step(6);
    expect3("R8 relatch at release", 3'b010);
    uv_flag = 1'b0; step(6);
    expect3("R8 latch holds after clear", 3'b010);
    toggle_recover("R8");
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        prot_mode = 2'(m); step(4);
        expect_cfg("R9 reserved prot_mode", 1'b1);
        expect3("R9 reserved prot_mode hiz", 3'b011);
      end
    end
    prot_mode = 2'b01; out_mode = 1'b1; step(4);
    expect_cfg("R9 reserved out_mode", 1'b1);
    expect3("R9 reserved out_mode hiz", 3'b011);
    out_mode = 1'b0; step(4);
    expect_cfg("R9 valid again", 1'b0);
    expect3("R9 running again", 3'b111);
  endtask

  initial begin
    step(1);
    t_reset();
    t_normal();
    t_ocuv(1'b0);
    t_ocuv(1'b1);
    t_ote();
    t_warn();
    t_fault_at_release();
    t_modes();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule